// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block sequences the operating states of a single-wire LIN bus transceiver. It runs the power-up path from unpowered into sleep. It watches a filtered enable pin to move between sleep, standby and normal. In sleep it detects a remote wake-up from the sampled bus level. All filter times are counted in clock cycles of a synchronous clock.

In normal mode the transmit pin steers a dominant-drive command and the receive pin mirrors the bus. Two gates can hold the transmitter off without changing the mode:
- a thermal gate, which re-arms only after the transmit pin has been seen recessive;
- a battery-monitor gate.

The analog front end supplies the supply-reset, battery and thermal flags and the bus comparator as digital levels.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `por_ok` is 0 the `mode` output (encoding 0 unpowered, 1 sleep, 2 standby, 3 normal) becomes 0 on the next clock from any mode. In that mode `tx_en`=0, `bus_drive`=0, `pullup_en`=0, `rxd_hiz`=1 and `txd_pd_strong`=0.
- R2: With `por_ok` at 1, unpowered moves to sleep (mode 1). In sleep the receive pin stays released (`rxd_hiz`=1), the pulldown stays weak, and the pull-up and transmitter are off.
- R3: From sleep or standby, normal mode is entered only after the synchronised enable has been high for `EN_CYC` consecutive cycles. A shorter high pulse leaves the mode unchanged.
- R4: From normal, sleep is entered only after the synchronised enable has been low for `DIS_CYC` consecutive cycles. A shorter low glitch leaves the mode normal.
- R5: In sleep, a bus dominant level (`bus_dom`=1) held for at least `WAKE_CYC` cycles and then followed by recessive leads to standby `STB_CYC` cycles after the recessive edge. Standby drives RxD low (`rxd_low`=1, `rxd_hiz`=0), selects the strong TxD pulldown and enables the pull-up, with the transmitter off.
- R6: A dominant pulse shorter than `WAKE_CYC` is discarded. The block stays in sleep with RxD released.
- R7: In standby, once the enable pin is seen high, RxD is released and the TxD pulldown returns to weak. This happens while the mode is still standby, before the enable filter ends.
- R8: In normal mode with both gates open, `bus_drive` equals the inverse of the synchronised `txd_pin`. `rxd_low` follows the synchronised `bus_dom`, and `pullup_en`=1.
- R9: When `therm_hot`=1, `bus_drive` and `tx_en` fall to 0 by the next clock. After `therm_hot` clears they stay 0 until `txd_pin` has been seen high.
- R10: When `bat_ok`=0 in normal mode, the transmitter is held off. The mode stays normal and `rxd_low` still follows the bus. Driving resumes when `bat_ok` returns to 1.
- R11: There is no dominant timeout: a transmit pin held low keeps `bus_drive`=1 for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| por_ok | input | 1 | Supply above reset level (hysteretic flag) |
| bat_ok | input | 1 | Battery monitor above threshold (hysteretic flag) |
| therm_hot | input | 1 | Junction over thermal shutdown limit |
| en_pin | input | 1 | Enable pin, asynchronous |
| txd_pin | input | 1 | Transmit data pin, low = dominant, asynchronous |
| bus_dom | input | 1 | Bus comparator, 1 = dominant, asynchronous |
| mode | output | 2 | Current mode: 0 unpowered, 1 sleep, 2 standby, 3 normal |
| tx_en | output | 1 | Transmitter allowed to drive |
| bus_drive | output | 1 | Command to pull the bus dominant |
| rxd_low | output | 1 | Drive the receive pin low |
| rxd_hiz | output | 1 | Release the receive pin |
| pullup_en | output | 1 | Connect the slave pull-up on the bus |
| txd_pd_strong | output | 1 | Strong TxD pulldown select (0 = weak) |

## Verification
The in-module assertions watch the following on every cycle:
- the forced drop to unpowered;
- that sleep keeps the bus and receive pin idle;
- that dominant drive never occurs outside normal mode;
- that normal is only entered with the enable pin high;
- that the thermal gate never re-arms while the transmit pin is low.

The filter lengths, the discarding of short wake pulses and the standby pin override can only be shown by the directed scenarios. The same holds for the battery gate leaving the mode untouched and the absence of a dominant timeout. Each of these depends on a sequence of stimulus over many cycles.

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int EN_CYC   = 20,
  parameter int DIS_CYC  = 20,
  parameter int WAKE_CYC = 70,
  parameter int STB_CYC  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       bat_ok,
  input  logic       therm_hot,
  input  logic       en_pin,
  input  logic       txd_pin,
  input  logic       bus_dom,
  output logic [1:0] mode,
  output logic       tx_en,
  output logic       bus_drive,
  output logic       rxd_low,
  output logic       rxd_hiz,
  output logic       pullup_en,
  output logic       txd_pd_strong
);
  localparam int CW = $clog2(EN_CYC + DIS_CYC + WAKE_CYC + STB_CYC + 2);
  localparam logic [CW-1:0] EN_L   = CW'(EN_CYC - 1);
  localparam logic [CW-1:0] DIS_L  = CW'(DIS_CYC - 1);
  localparam logic [CW-1:0] WAKE_L = CW'(WAKE_CYC);
  localparam logic [CW-1:0] STB_L  = CW'(STB_CYC - 1);
  localparam logic [1:0] M_OFF = 2'd0, M_SLP = 2'd1, M_STB = 2'd2, M_NRM = 2'd3;

  logic [1:0] en_sy, txd_sy, bus_sy;
  logic en_s, txd_s, bus_s;
  logic [1:0] nxt;
  logic [CW-1:0] en_cnt, bus_cnt;
  logic armed, therm_arm, en_go, en_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_sy <= '0; txd_sy <= 2'b11; bus_sy <= '0;
    end else begin
      en_sy  <= {en_sy[0], en_pin};
      txd_sy <= {txd_sy[0], txd_pin};
      bus_sy <= {bus_sy[0], bus_dom};
    end

  assign en_s  = en_sy[1];
  assign txd_s = txd_sy[1];
  assign bus_s = bus_sy[1];

  assign en_go  = (mode == M_SLP || mode == M_STB) ? en_s : (mode == M_NRM) ? !en_s : 1'b0;
  assign en_hit = en_go && (en_cnt >= ((mode == M_NRM) ? DIS_L : EN_L));

  always_comb begin
    nxt = mode;
    if (!por_ok) nxt = M_OFF;
    else case (mode)
      M_OFF: nxt = M_SLP;
      M_SLP: if (en_hit) nxt = M_NRM;
             else if (armed && bus_cnt >= STB_L) nxt = M_STB;
      M_STB: if (en_hit) nxt = M_NRM;
      default: if (en_hit) nxt = M_SLP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_OFF; en_cnt <= '0; bus_cnt <= '0; armed <= 1'b0;
    end else begin
      mode <= nxt;
      if (nxt != mode || !en_go) en_cnt <= '0;
      else en_cnt <= en_cnt + 1'b1;
      if (nxt != mode || mode != M_SLP) begin
        bus_cnt <= '0; armed <= 1'b0;
      end else if (armed) bus_cnt <= bus_cnt + 1'b1;
      else if (bus_s) begin
        if (bus_cnt < WAKE_L) bus_cnt <= bus_cnt + 1'b1;
      end else begin
        bus_cnt <= '0;
        armed   <= (bus_cnt >= WAKE_L);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) therm_arm <= 1'b1;
    else if (therm_hot) therm_arm <= 1'b0;
    else if (txd_s) therm_arm <= 1'b1;

  assign tx_en         = (mode == M_NRM) && bat_ok && therm_arm;
  assign bus_drive     = tx_en && !txd_s;
  assign rxd_low       = ((mode == M_STB) && !en_s) || ((mode == M_NRM) && bus_s);
  assign rxd_hiz       = !rxd_low;
  assign pullup_en     = (mode == M_STB) || (mode == M_NRM);
  assign txd_pd_strong = (mode == M_STB) && !en_s;

  assert_unpowered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (mode == M_OFF && !pullup_en && rxd_hiz && !bus_drive));
  assert_sleep_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLP) |-> (!pullup_en && rxd_hiz && !tx_en && !txd_pd_strong));
  assert_norm_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == M_NRM) |-> en_s);
  assert_drive_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (mode == M_NRM));
  assert_therm_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    therm_hot |=> !tx_en);
  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!therm_arm && !txd_s) |=> !therm_arm);
  assert_bat_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NRM && !bat_ok && por_ok && en_s) |=> (mode == M_NRM));
endmodule

// File: tb/lin_mode_ctrl_test.sv
module lin_mode_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic por_ok = 0, bat_ok = 1, therm_hot = 0, en_pin = 0, txd_pin = 1, bus_dom = 0;
  logic [1:0] mode;
  logic tx_en, bus_drive, rxd_low, rxd_hiz, pullup_en, txd_pd_strong;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lin_mode_ctrl uut (.clk, .rst_n, .por_ok, .bat_ok, .therm_hot, .en_pin, .txd_pin,
    .bus_dom, .mode, .tx_en, .bus_drive, .rxd_low, .rxd_hiz, .pullup_en, .txd_pd_strong);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(3); rst_n = 1; cyc(3);
    chk("R1 mode", mode, 0); chk("R1 pullup", pullup_en, 0);
    chk("R1 rxd_hiz", rxd_hiz, 1); chk("R1 tx_en", tx_en, 0);
    chk("R1 strong", txd_pd_strong, 0);
  endtask

  task automatic t_powerup;
    por_ok = 1; cyc(2);
    chk("R2 mode", mode, 1); chk("R2 rxd_hiz", rxd_hiz, 1);
    chk("R2 strong", txd_pd_strong, 0); chk("R2 pullup", pullup_en, 0);
  endtask

  task automatic t_enable;
    en_pin = 1; cyc(8); en_pin = 0; cyc(10);
    chk("R3 short pulse", mode, 1);
    en_pin = 1; cyc(12);
    chk("R3 not yet", mode, 1);
    cyc(20);
    chk("R3 normal", mode, 3);
  endtask

  task automatic t_normal;
    txd_pin = 0; cyc(4); chk("R8 drive", bus_drive, 1);
    txd_pin = 1; cyc(4); chk("R8 release", bus_drive, 0);
    bus_dom = 1; cyc(4); chk("R8 rxd dom", rxd_low, 1);
    bus_dom = 0; cyc(4); chk("R8 rxd rec", rxd_hiz, 1);
    chk("R8 pullup", pullup_en, 1);
  endtask

  task automatic t_thermal;
    txd_pin = 0; cyc(4); chk("R9 pre", bus_drive, 1);
    therm_hot = 1; cyc(1); chk("R9 off", bus_drive, 0);
    therm_hot = 0; cyc(10); chk("R9 held off", bus_drive, 0);
    chk("R9 tx_en", tx_en, 0);
    txd_pin = 1; cyc(4); chk("R9 rearm", tx_en, 1);
    txd_pin = 0; cyc(4); chk("R9 drive again", bus_drive, 1);
    txd_pin = 1; cyc(4);
  endtask

  task automatic t_battery;
    txd_pin = 0; bat_ok = 0; cyc(4);
    chk("R10 gated", bus_drive, 0);
    bus_dom = 1; cyc(40);
    chk("R10 mode", mode, 3); chk("R10 rx", rxd_low, 1);
    bus_dom = 0; bat_ok = 1; cyc(2);
    chk("R10 resume", bus_drive, 1);
  endtask

  task automatic t_no_timeout;
    cyc(3000); chk("R11 still dominant", bus_drive, 1);
    txd_pin = 1; cyc(4);
  endtask

  task automatic t_disable;
    en_pin = 0; cyc(8); en_pin = 1; cyc(10);
    chk("R4 glitch", mode, 3);
    en_pin = 0; cyc(12); chk("R4 not yet", mode, 3);
    cyc(20); chk("R4 sleep", mode, 1);
  endtask

  task automatic t_wake;
    bus_dom = 1; cyc(50); bus_dom = 0; cyc(40);
    chk("R6 stays sleep", mode, 1); chk("R6 rxd", rxd_hiz, 1);
    bus_dom = 1; cyc(90); bus_dom = 0; cyc(5);
    chk("R5 delay", mode, 1);
    cyc(15);
    chk("R5 standby", mode, 2); chk("R5 rxd", rxd_low, 1);
    chk("R5 strong", txd_pd_strong, 1); chk("R5 pullup", pullup_en, 1);
    chk("R5 tx off", tx_en, 0);
  endtask

  task automatic t_stb_exit;
    en_pin = 1; cyc(4);
    chk("R7 mode still standby", mode, 2);
    chk("R7 rxd released", rxd_hiz, 1); chk("R7 weak", txd_pd_strong, 0);
    cyc(30); chk("R3 from standby", mode, 3);
  endtask

  task automatic t_por_drop;
    por_ok = 0; cyc(2);
    chk("R1 forced", mode, 0); chk("R1 pullup off", pullup_en, 0);
  endtask

  initial begin
    t_reset; t_powerup; t_enable; t_normal; t_thermal; t_battery;
    t_no_timeout; t_disable; t_wake; t_stb_exit; t_por_drop;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule